// File: doc/BRIEF.md
# Local Scan-Enable Generator Cell

This cell is one extra bit placed inside a scan chain. It turns the slow, tester-driven global scan-enable into the local scan-enable that drives the rest of that chain's scan flip-flops. During shift, the cell acts as a single scan segment. The last value shifted into it is the control bit for the pattern. Once the global enable drops, that bit alone sets whether the chain shifts or works functionally during the launch and capture cycles.

A parameter selects between two variants. The hold variant keeps the local enable at the control bit through both the launch and the capture cycles. A chain with control bit 1 then launches a transition from the scan path and captures nothing. The at-speed variant clears its bit on the launch edge. A chain with control bit 1 therefore launches from the scan path and captures at the following edge, with no fast global enable from the tester. With control bit 0, both variants give functional launch and capture. When the global enable returns, it forces the local enable high at once so that the response can be shifted out.

Top module: `scan_en_gen`

## Requirements
- R1: While rst_ni is 0, the stored bit is 0 (scan_o = 0), independent of the clock.
- R2: While gsen_i is 1, lsen_o is 1, whatever the stored bit is, and with no clock edge needed.
- R3: While gsen_i is 0, lsen_o equals the stored bit seen on scan_o.
- R4: At a rising clock edge with gsen_i = 1, the stored bit takes the value of scan_i, so the cell lengthens the chain by exactly one bit.
- R5: Hold variant (VARIANT = VAR_SLOW, encoding 0): at a rising edge with gsen_i = 0, the stored bit keeps its value.
- R6: At-speed variant (VARIANT = VAR_FAST, encoding 1): at a rising edge with gsen_i = 0, the stored bit becomes 0. A control bit of 1 therefore gives lsen_o = 1 before the launch edge and 0 after it.
- R7: With gsen_i = 0, scan_i has no effect on the stored bit in either variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gsen_i | input | 1 | Global scan-enable from the tester |
| scan_i | input | 1 | Serial data from the previous chain bit |
| scan_o | output | 1 | Stored control bit, serial data to the next chain bit |
| lsen_o | output | 1 | Local scan-enable for the chain's flip-flops |

## Verification
Both variants run in parallel on the same stimulus. This exposes every cycle where their next-state rules differ. Directed sequences shift in a control bit of 1 and then of 0, drop the global enable for a launch and a capture cycle, and then raise it again. Those sequences separate the hold, clear and functional outcomes, and show the forced return to shift. A sequence that toggles scan_i while the enable is low checks that the serial input is ignored. A mid-run reset checks the asynchronous clear. Random enable and data patterns with a fixed seed then cover mixed short and long shift and capture runs.

// File: rtl/lseg_pkg.sv
package lseg_pkg;
  typedef enum logic {
    VAR_SLOW = 1'b0,
    VAR_FAST = 1'b1
  } lseg_variant_e;
endpackage

// File: rtl/lseg_next_state.sv
module lseg_next_state
  import lseg_pkg::*;
#(
  parameter lseg_variant_e VARIANT = VAR_SLOW
) (
  input  logic gsen_i,
  input  logic scan_i,
  input  logic q_i,
  output logic d_o
);
  logic func_d;

  generate
    if (VARIANT == VAR_FAST) begin : g_fast
      // constant 0 on the functional path: bit clears on launch edge
      assign func_d = 1'b0;
    end else begin : g_slow
      // recirculate: control bit held through launch and capture
      assign func_d = q_i;
    end
  endgenerate

  assign d_o = gsen_i ? scan_i : func_d;
endmodule

// File: rtl/lseg_ctrl_ff.sv
module lseg_ctrl_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/lseg_out_stage.sv
module lseg_out_stage (
  input  logic gsen_i,
  input  logic q_i,
  output logic lsen_o
);
  assign lsen_o = gsen_i | q_i;
endmodule

// File: rtl/scan_en_gen.sv
module scan_en_gen
  import lseg_pkg::*;
#(
  parameter lseg_variant_e VARIANT = VAR_SLOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gsen_i,
  input  logic scan_i,
  output logic scan_o,
  output logic lsen_o
);
  logic d;
  logic q;

  lseg_next_state #(.VARIANT(VARIANT)) u_ns (
    .gsen_i(gsen_i),
    .scan_i(scan_i),
    .q_i   (q),
    .d_o   (d)
  );

  lseg_ctrl_ff u_ff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d),
    .q_o   (q)
  );

  lseg_out_stage u_out (
    .gsen_i(gsen_i),
    .q_i   (q),
    .lsen_o(lsen_o)
  );

  assign scan_o = q;
endmodule

// File: rtl/lseg_checker.sv
module lseg_checker
  import lseg_pkg::*;
#(
  parameter lseg_variant_e VARIANT = VAR_SLOW
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gsen_i,
  input logic scan_i,
  input logic scan_o,
  input logic lsen_o
);
  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> !scan_o);

  a_r2_shift_forces_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsen_i |-> lsen_o);

  a_r3_enable_tracks_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gsen_i |-> (lsen_o == scan_o));

  a_r4_one_bit_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsen_i |=> (scan_o == $past(scan_i)));

  generate
    if (VARIANT == VAR_FAST) begin : g_fast_chk
      a_r6_clear_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gsen_i |=> !scan_o);
    end else begin : g_slow_chk
      a_r5_hold_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gsen_i |=> $stable(scan_o));
    end
  endgenerate
endmodule

bind scan_en_gen lseg_checker #(.VARIANT(VARIANT)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .gsen_i(gsen_i),
  .scan_i(scan_i),
  .scan_o(scan_o),
  .lsen_o(lsen_o)
);

// File: tb/scan_en_gen_tb.sv
module scan_en_gen_tb;
  import lseg_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic gsen = 1'b1;
  logic scan_in = 1'b0;
  logic so_s, ls_s, so_f, ls_f;
  logic mq_s = 1'b0;
  logic mq_f = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scan_en_gen #(.VARIANT(VAR_SLOW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .gsen_i(gsen), .scan_i(scan_in),
    .scan_o(so_s), .lsen_o(ls_s));

  scan_en_gen #(.VARIANT(VAR_FAST)) u_dut_fast (
    .clk_i(clk), .rst_ni(rst_ni), .gsen_i(gsen), .scan_i(scan_in),
    .scan_o(so_f), .lsen_o(ls_f));

  function automatic logic exp_lsen(logic g, logic q);
    return g | q;
  endfunction

  function automatic logic exp_next(logic fast, logic g, logic s, logic q);
    if (g) return s;
    return fast ? 1'b0 : q;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; applies inputs for one cycle and checks both sides of the edge
  task automatic cycle(logic g, logic s, string hold_tag);
    gsen = g;
    scan_in = s;
    #1;
    chk(g ? "R2 slow" : "R3 slow", ls_s, exp_lsen(g, mq_s));
    chk(g ? "R2 fast" : "R3 fast", ls_f, exp_lsen(g, mq_f));
    @(posedge clk);
    mq_s = exp_next(1'b0, g, s, mq_s);
    mq_f = exp_next(1'b1, g, s, mq_f);
    @(negedge clk);
    chk(g ? "R4 slow" : {"R5 ", hold_tag}, so_s, mq_s);
    chk(g ? "R4 fast" : {"R6 ", hold_tag}, so_f, mq_f);
  endtask

  task automatic pattern(logic c);
    cycle(1'b1, c, "");
    cycle(1'b0, 1'b0, "launch");
    cycle(1'b0, 1'b0, "capture");
    cycle(1'b1, 1'b0, "");
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2;
    chk("R1 slow", so_s, 1'b0);
    chk("R1 fast", so_f, 1'b0);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    pattern(1'b1);
    pattern(1'b0);
    pattern(1'b1);

    // R7: serial input toggles while enable is low
    cycle(1'b1, 1'b1, "");
    for (int i = 0; i < 4; i++) cycle(1'b0, i[0], "R7");
    cycle(1'b1, 1'b0, "");
    for (int i = 0; i < 4; i++) cycle(1'b0, ~i[0], "R7");

    // R1: asynchronous clear mid-run
    cycle(1'b1, 1'b1, "");
    rst_ni = 1'b0;
    #1;
    chk("R1 async slow", so_s, 1'b0);
    chk("R1 async fast", so_f, 1'b0);
    mq_s = 1'b0;
    mq_f = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 400; i++) begin
      logic g, s;
      g = ($urandom % 3) != 0;
      s = $urandom % 2;
      cycle(g, s, "R7 rand");
    end
    done = 1;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
  end

  initial begin
    wait (done || $time >= 100000);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule